// File: doc/BRIEF.md
# Register Window Access Guard

This block sits beside a cipher engine's register window and watches every access made through a single-cycle read/write port. It follows the engine's working phase (idle, block processing, or sub-key expansion) from three strobes that the engine drives. It uses that phase to sort each access into legal or illegal. A legal access reaches its target: the mode word, the interrupt mask, the status word, the engine's output words, or a forwarded write to the engine's key, input and vector words. An illegal access is dropped and logged.

The log holds a sticky violation flag and a 4-bit cause code. Both keep their value until software writes the soft-reset bit of the control word. A six-bit group of protection settings inside the mode word is guarded by a write key. An interrupt line combines data-ready, violation and tag-ready status with a mask that is set and cleared through separate registers.

Top module: `regwin_guard`

## Requirements
- R1: A write to an input data word (word offsets 0x40 to 0x4C) while the phase is processing and the start-mode field (mode bits 9:8) equals 2 is an illegal access with cause 0. It does not raise `ewr_en`. In any other case the write is forwarded on `ewr_en`/`ewr_idx`/`ewr_data` in the same cycle.
- R2: A read of an output word (0x50 to 0x5C) during processing is an illegal access with cause 1 and returns zero. In idle, the same read returns word k of `eng_odata`.
- R3: A mode-word write (0x04) during processing is an illegal access with cause 2. The mode word and the protection bits keep their old values.
- R4: During sub-key expansion, an output-word read is an illegal access with cause 3, and a mode-word write is an illegal access with cause 4 and is dropped.
- R5: A read of any write-only word is an illegal access with cause 5 and returns zero. The write-only words are control 0x00, mask-set 0x10, mask-clear 0x14, key words 0x20 to 0x3C, input words and vector words 0x60 to 0x6C.
- R6: The status word (0x1C) shows the violation flag at bit 8 and the cause at bits 15:12. The first cause is kept while the flag is set. Only a control write with bit 8 set clears the flag and the cause.
- R7: Mode bits 29:24 (`prot_bits`) change only when the same write carries 0xE in bits 23:20. Bits 19:0 are written regardless of the key. Bits 23:20 always read back as zero.
- R8: A write to 0x10 sets the mask bits and a write to 0x14 clears them, using bit 0 for data-ready, bit 8 for violation and bit 16 for tag-ready. Clear wins over set. 0x18 reads the mask. `irq` is the OR of each status bit ANDed with its mask bit.
- R9: Status bit 0 (data-ready) is set by `eng_data_ready` and cleared by a control write with bit 0 set, by soft reset, or by a legal output-word read. Status bit 16 (tag-ready) is set by `eng_tag_ready` and cleared only by soft reset.
- R10: The phase strobes take priority in this order: `ph_end`, then `ph_subkey`, then `ph_proc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte address of the word |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the cycle of the access |
| eng_odata | input | 128 | Engine output words, word k at bits 32k+31:32k |
| ph_proc | input | 1 | Engine starts block processing |
| ph_subkey | input | 1 | Engine starts sub-key expansion |
| ph_end | input | 1 | Engine returns to idle |
| eng_data_ready | input | 1 | Data-ready event pulse |
| eng_tag_ready | input | 1 | Tag-ready event pulse |
| ewr_en | output | 1 | Forwarded write to an engine word |
| ewr_idx | output | 6 | Word index (address bits 7:2) of the forwarded write |
| ewr_data | output | 32 | Data of the forwarded write |
| viol_flag | output | 1 | Sticky violation flag |
| viol_code | output | 4 | Cause of the first violation |
| prot_bits | output | 6 | Key-guarded protection settings |
| irq | output | 1 | Masked interrupt |

## Verification
The bench keeps a violation already logged and then makes a second, different one. A design that overwrote the cause would show 1 where 0 is expected. It writes the mode word with a wrong key and while busy. A design that ignored either guard would change `prot_bits` or the stored start mode. It fires competing phase strobes in the same cycle, checks that a start write leaves tag-ready set, and writes input data while processing with start mode 0. A design with the wrong priority would classify the next access in the wrong phase. A design that checked only the phase would block a legal forward.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int WIDX_W     = ADDR_W - 2;
    localparam int KEY_WORDS  = 8;
    localparam int BLK_WORDS  = 4;
    localparam int BLK_SEL_W  = $clog2(BLK_WORDS);
    localparam int KEY_BASE   = 8;
    localparam int DIN_BASE   = KEY_BASE + KEY_WORDS;
    localparam int DOUT_BASE  = DIN_BASE + BLK_WORDS;
    localparam int IV_BASE    = DOUT_BASE + BLK_WORDS;
    localparam int CODE_W     = 4;

    // mode word layout
    localparam int MODE_LO_W  = 20;
    localparam int SMOD_LSB   = 8;
    localparam int KEY_LSB    = 20;
    localparam int PROT_LSB   = 24;
    localparam int PROT_W     = 6;
    localparam logic [3:0] KEY_PASS = 4'hE;
    localparam logic [1:0] SMOD_GUARD = 2'd2;

    // status / control layout
    localparam int ST_DR      = 0;
    localparam int ST_VIOL    = 8;
    localparam int CODE_LSB   = 12;
    localparam int ST_TAG     = 16;
    localparam int CTL_START  = 0;
    localparam int CTL_SWRST  = 8;
    localparam int NSRC       = 3;

    typedef enum logic [1:0] {PH_IDLE, PH_PROC, PH_SUBKEY} phase_e;

    typedef enum logic [3:0] {
        RG_CTRL, RG_MODE, RG_MSET, RG_MCLR, RG_MASK, RG_STAT,
        RG_KEY, RG_DIN, RG_DOUT, RG_IV, RG_NONE
    } reg_e;

    localparam logic [CODE_W-1:0] VC_DIN_PROC    = 4'd0;
    localparam logic [CODE_W-1:0] VC_DOUT_PROC   = 4'd1;
    localparam logic [CODE_W-1:0] VC_MODE_PROC   = 4'd2;
    localparam logic [CODE_W-1:0] VC_DOUT_SUBKEY = 4'd3;
    localparam logic [CODE_W-1:0] VC_MODE_SUBKEY = 4'd4;
    localparam logic [CODE_W-1:0] VC_WO_READ     = 4'd5;

    typedef struct packed {
        logic              hit;
        logic [CODE_W-1:0] code;
    } viol_t;

    function automatic reg_e decode(input logic [ADDR_W-1:0] a);
        int wi;
        wi = int'(a[ADDR_W-1:2]);
        if (a[1:0] != 2'b00)                             return RG_NONE;
        if (wi == 0)                                     return RG_CTRL;
        if (wi == 1)                                     return RG_MODE;
        if (wi == 4)                                     return RG_MSET;
        if (wi == 5)                                     return RG_MCLR;
        if (wi == 6)                                     return RG_MASK;
        if (wi == 7)                                     return RG_STAT;
        if (wi >= KEY_BASE  && wi < DIN_BASE)            return RG_KEY;
        if (wi >= DIN_BASE  && wi < DOUT_BASE)           return RG_DIN;
        if (wi >= DOUT_BASE && wi < IV_BASE)             return RG_DOUT;
        if (wi >= IV_BASE   && wi < IV_BASE + BLK_WORDS) return RG_IV;
        return RG_NONE;
    endfunction

    function automatic logic write_only(input reg_e r);
        return (r == RG_CTRL) || (r == RG_MSET) || (r == RG_MCLR) ||
               (r == RG_KEY)  || (r == RG_DIN)  || (r == RG_IV);
    endfunction

    // bit position of interrupt source i: data-ready, violation, tag-ready
    function automatic int src_pos(input int i);
        return i * 8;
    endfunction

endpackage

// File: rtl/regwin_phase.sv
module regwin_phase
    import regwin_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   go_proc,
    input  logic   go_subkey,
    input  logic   go_end,
    output phase_e phase
);
    always_ff @(posedge clk) begin
        if (rst)            phase <= PH_IDLE;
        else if (go_end)    phase <= PH_IDLE;
        else if (go_subkey) phase <= PH_SUBKEY;
        else if (go_proc)   phase <= PH_PROC;
    end
endmodule

// File: rtl/regwin_classify.sv
module regwin_classify
    import regwin_pkg::*;
(
    input  logic       valid,
    input  logic       write,
    input  reg_e       target,
    input  phase_e     phase,
    input  logic [1:0] smod,
    output viol_t      viol
);
    always_comb begin
        viol = '{hit: 1'b0, code: '0};
        if (valid && write) begin
            if (target == RG_DIN && phase == PH_PROC && smod == SMOD_GUARD)
                viol = '{hit: 1'b1, code: VC_DIN_PROC};
            else if (target == RG_MODE && phase == PH_PROC)
                viol = '{hit: 1'b1, code: VC_MODE_PROC};
            else if (target == RG_MODE && phase == PH_SUBKEY)
                viol = '{hit: 1'b1, code: VC_MODE_SUBKEY};
        end else if (valid) begin
            if (target == RG_DOUT && phase == PH_PROC)
                viol = '{hit: 1'b1, code: VC_DOUT_PROC};
            else if (target == RG_DOUT && phase == PH_SUBKEY)
                viol = '{hit: 1'b1, code: VC_DOUT_SUBKEY};
            else if (write_only(target))
                viol = '{hit: 1'b1, code: VC_WO_READ};
        end
    end
endmodule

// File: rtl/regwin_irq.sv
module regwin_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [N-1:0] sel_bits,
    input  logic [N-1:0] src,
    output logic [N-1:0] mask,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)                          mask[i] <= 1'b0;
            else if (clr_we && sel_bits[i])   mask[i] <= 1'b0;
            else if (set_we && sel_bits[i])   mask[i] <= 1'b1;
        end
    end

    assign irq = |(mask & src);
endmodule

// File: rtl/regwin_guard.sv
module regwin_guard
    import regwin_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          acc_valid,
    input  logic                          acc_write,
    input  logic [ADDR_W-1:0]             acc_addr,
    input  logic [DATA_W-1:0]             acc_wdata,
    output logic [DATA_W-1:0]             acc_rdata,
    input  logic [BLK_WORDS*DATA_W-1:0]   eng_odata,
    input  logic                          ph_proc,
    input  logic                          ph_subkey,
    input  logic                          ph_end,
    input  logic                          eng_data_ready,
    input  logic                          eng_tag_ready,
    output logic                          ewr_en,
    output logic [WIDX_W-1:0]             ewr_idx,
    output logic [DATA_W-1:0]             ewr_data,
    output logic                          viol_flag,
    output logic [CODE_W-1:0]             viol_code,
    output logic [PROT_W-1:0]             prot_bits,
    output logic                          irq
);
    phase_e               phase;
    reg_e                 target;
    viol_t                viol;
    logic                 legal_wr, legal_rd;
    logic [MODE_LO_W-1:0] mode_lo;
    logic                 st_dr, st_tag;
    logic [NSRC-1:0]      mask, sel_bits, src;
    logic                 ctl_wr, do_swrst, do_start, dout_rd;
    logic [BLK_SEL_W-1:0] dout_sel;
    logic [DATA_W-1:0]    mode_word, stat_word, mask_word;

    assign target = decode(acc_addr);

    regwin_phase u_phase (
        .clk(clk), .rst(rst), .go_proc(ph_proc), .go_subkey(ph_subkey),
        .go_end(ph_end), .phase(phase)
    );

    regwin_classify u_cls (
        .valid(acc_valid), .write(acc_write), .target(target), .phase(phase),
        .smod(mode_lo[SMOD_LSB +: 2]), .viol(viol)
    );

    assign legal_wr = acc_valid &&  acc_write && !viol.hit;
    assign legal_rd = acc_valid && !acc_write && !viol.hit;
    assign ctl_wr   = legal_wr && target == RG_CTRL;
    assign do_swrst = ctl_wr && acc_wdata[CTL_SWRST];
    assign do_start = ctl_wr && acc_wdata[CTL_START];
    assign dout_rd  = legal_rd && target == RG_DOUT;
    assign dout_sel = BLK_SEL_W'(int'(acc_addr[ADDR_W-1:2]) - DOUT_BASE);

    // forward of engine-side write-only words
    assign ewr_en   = legal_wr && (target == RG_KEY || target == RG_DIN || target == RG_IV);
    assign ewr_idx  = acc_addr[ADDR_W-1:2];
    assign ewr_data = acc_wdata;

    // violation log: first cause kept until soft reset
    always_ff @(posedge clk) begin
        if (rst || do_swrst) begin
            viol_flag <= 1'b0;
            viol_code <= '0;
        end else if (viol.hit && !viol_flag) begin
            viol_flag <= 1'b1;
            viol_code <= viol.code;
        end
    end

    // mode word with key-guarded protection group
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_lo   <= '0;
            prot_bits <= '0;
        end else if (legal_wr && target == RG_MODE) begin
            mode_lo <= acc_wdata[MODE_LO_W-1:0];
            if (acc_wdata[KEY_LSB +: 4] == KEY_PASS)
                prot_bits <= acc_wdata[PROT_LSB +: PROT_W];
        end
    end

    // event status: set beats clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            st_dr  <= 1'b0;
            st_tag <= 1'b0;
        end else begin
            if (eng_data_ready)                        st_dr <= 1'b1;
            else if (do_start || do_swrst || dout_rd)  st_dr <= 1'b0;
            if (eng_tag_ready)                         st_tag <= 1'b1;
            else if (do_swrst)                         st_tag <= 1'b0;
        end
    end

    assign src = {st_tag, viol_flag, st_dr};
    for (genvar i = 0; i < NSRC; i++) begin : g_sel
        assign sel_bits[i] = acc_wdata[src_pos(i)];
    end

    regwin_irq #(.N(NSRC)) u_irq (
        .clk(clk), .rst(rst),
        .set_we(legal_wr && target == RG_MSET),
        .clr_we(legal_wr && target == RG_MCLR),
        .sel_bits(sel_bits), .src(src), .mask(mask), .irq(irq)
    );

    always_comb begin
        mode_word = '0;
        mode_word[MODE_LO_W-1:0]      = mode_lo;
        mode_word[PROT_LSB +: PROT_W] = prot_bits;
        stat_word = '0;
        stat_word[ST_DR]              = st_dr;
        stat_word[ST_VIOL]            = viol_flag;
        stat_word[CODE_LSB +: CODE_W] = viol_code;
        stat_word[ST_TAG]             = st_tag;
        mask_word = '0;
        for (int i = 0; i < NSRC; i++) mask_word[src_pos(i)] = mask[i];
    end

    always_comb begin
        acc_rdata = '0;
        if (legal_rd) begin
            case (target)
                RG_MODE: acc_rdata = mode_word;
                RG_MASK: acc_rdata = mask_word;
                RG_STAT: acc_rdata = stat_word;
                RG_DOUT: acc_rdata = eng_odata[int'(dout_sel)*DATA_W +: DATA_W];
                default: acc_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/regwin_guard_chk.sv
module regwin_guard_chk
    import regwin_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              wd_swrst,
    input logic [3:0]        wd_key,
    input logic [DATA_W-1:0] acc_rdata,
    input logic              viol_flag,
    input logic [CODE_W-1:0] viol_code,
    input logic [PROT_W-1:0] prot_bits,
    input logic [1:0]        phase
);
    logic swrst_w, mode_w;
    assign swrst_w = acc_valid && acc_write && acc_addr == 8'h00 && wd_swrst;
    assign mode_w  = acc_valid && acc_write && acc_addr == 8'h04;

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        viol_flag && !swrst_w |=> viol_flag);

    a_r6_code_kept: assert property (@(posedge clk) disable iff (rst)
        viol_flag && !swrst_w |=> $stable(viol_code));

    a_r6_swrst_clears: assert property (@(posedge clk) disable iff (rst)
        swrst_w |=> !viol_flag && viol_code == '0);

    a_r7_prot_needs_key: assert property (@(posedge clk) disable iff (rst)
        mode_w && wd_key != KEY_PASS |=> $stable(prot_bits));

    a_r3_busy_mode_dropped: assert property (@(posedge clk) disable iff (rst)
        mode_w && phase != 2'(PH_IDLE) |=> $stable(prot_bits));

    a_r7_key_reads_zero: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_write && acc_addr == 8'h04 |-> acc_rdata[23:20] == 4'h0);

    a_r5_ctrl_reads_zero: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_write && acc_addr == 8'h00 |-> acc_rdata == '0);
endmodule

bind regwin_guard regwin_guard_chk u_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .wd_swrst(acc_wdata[8]), .wd_key(acc_wdata[23:20]),
    .acc_rdata(acc_rdata), .viol_flag(viol_flag), .viol_code(viol_code),
    .prot_bits(prot_bits), .phase(phase)
);

// File: tb/regwin_guard_test.sv
module regwin_guard_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         acc_valid = 1'b0, acc_write = 1'b0;
    logic [7:0]   acc_addr = '0;
    logic [31:0]  acc_wdata = '0;
    logic [31:0]  acc_rdata;
    logic [127:0] eng_odata;
    logic         ph_proc = 0, ph_subkey = 0, ph_end = 0;
    logic         eng_data_ready = 0, eng_tag_ready = 0;
    logic         ewr_en;
    logic [5:0]   ewr_idx;
    logic [31:0]  ewr_data;
    logic         viol_flag, irq;
    logic [3:0]   viol_code;
    logic [5:0]   prot_bits;

    int n_chk = 0, n_fail = 0;
    logic [31:0] cap_rd;
    logic        cap_en;
    logic [5:0]  cap_idx;

    always #10 clk = ~clk;

    assign eng_odata = {32'hA0A0_0003, 32'hA0A0_0002, 32'hA0A0_0001, 32'hA0A0_0000};

    regwin_guard uut (.*);

    // {write, addr, wdata, expected read data}
    localparam int NV = 16;
    localparam logic [72:0] TBL [NV] = '{
        {1'b0, 8'h04, 32'h0,          32'h0},
        {1'b1, 8'h04, 32'h2AE0_0200, 32'h0},
        {1'b0, 8'h04, 32'h0,          32'h2A00_0200},
        {1'b1, 8'h04, 32'h1550_0201, 32'h0},
        {1'b0, 8'h04, 32'h0,          32'h2A00_0201},
        {1'b1, 8'h04, 32'h3FE0_0200, 32'h0},
        {1'b0, 8'h04, 32'h0,          32'h3F00_0200},
        {1'b1, 8'h10, 32'h0001_0101, 32'h0},
        {1'b0, 8'h18, 32'h0,          32'h0001_0101},
        {1'b1, 8'h14, 32'h0000_0001, 32'h0},
        {1'b0, 8'h18, 32'h0,          32'h0001_0100},
        {1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h18, 32'h0,          32'h0001_0101},
        {1'b1, 8'h14, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h18, 32'h0,          32'h0},
        {1'b0, 8'h1C, 32'h0,          32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
        #5;
        cap_rd = acc_rdata; cap_en = ewr_en; cap_idx = ewr_idx;
        @(posedge clk); #2;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic strobe(input logic p, input logic s, input logic e,
                          input logic dr, input logic tg);
        @(negedge clk);
        ph_proc = p; ph_subkey = s; ph_end = e; eng_data_ready = dr; eng_tag_ready = tg;
        @(posedge clk); #2;
        ph_proc = 0; ph_subkey = 0; ph_end = 0; eng_data_ready = 0; eng_tag_ready = 0;
    endtask

    task automatic swrst();
        acc(1'b1, 8'h00, 32'h0000_0100);
    endtask

    task automatic status(input string req, input logic [31:0] exp);
        acc(1'b0, 8'h1C, 32'h0);
        chk(req, cap_rd, exp);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk("reset flag",  {31'b0, viol_flag}, 32'h0);
        chk("reset code",  {28'b0, viol_code}, 32'h0);
        chk("reset prot",  {26'b0, prot_bits}, 32'h0);
        chk("reset irq",   {31'b0, irq}, 32'h0);

        // table walk: mode key guard (R7) and mask set/clear (R8)
        for (int i = 0; i < NV; i++) begin
            acc(TBL[i][72], TBL[i][71:64], TBL[i][63:32]);
            if (!TBL[i][72])
                chk(TBL[i][71:64] == 8'h04 ? "R7 mode readback" : "R8 mask/status",
                    cap_rd, TBL[i][31:0]);
        end
        chk("R7 prot port", {26'b0, prot_bits}, 32'h3F);

        acc(1'b1, 8'h10, 32'h0001_0101);
        // R1: idle input write forwarded
        acc(1'b1, 8'h40, 32'hDEAD_0001);
        chk("R1 idle forward", {31'b0, cap_en}, 32'h1);
        chk("R1 forward index", {26'b0, cap_idx}, 32'd16);
        chk("R1 idle no violation", {31'b0, viol_flag}, 32'h0);
        // R1: processing with start mode 2
        strobe(1, 0, 0, 0, 0);
        acc(1'b1, 8'h44, 32'hDEAD_0002);
        chk("R1 busy write blocked", {31'b0, cap_en}, 32'h0);
        status("R1 code0 logged", 32'h0000_0100);
        chk("R8 irq on violation", {31'b0, irq}, 32'h1);
        // R2 in processing while flag set: R6 keeps first cause
        acc(1'b0, 8'h50, 32'h0);
        chk("R2 busy read zero", cap_rd, 32'h0);
        status("R6 first cause kept", 32'h0000_0100);
        swrst();
        chk("R6 swrst clears flag", {31'b0, viol_flag}, 32'h0);
        chk("R8 irq drops", {31'b0, irq}, 32'h0);
        acc(1'b0, 8'h54, 32'h0);
        chk("R2 busy read zero", cap_rd, 32'h0);
        status("R2 code1", 32'h0000_1100);
        swrst();
        // R3
        acc(1'b1, 8'h04, 32'h00E0_0000);
        status("R3 code2", 32'h0000_2100);
        acc(1'b0, 8'h04, 32'h0);
        chk("R3 mode unchanged", cap_rd, 32'h3F00_0200);
        swrst();
        // R4
        strobe(0, 0, 1, 0, 0);
        strobe(0, 1, 0, 0, 0);
        acc(1'b0, 8'h58, 32'h0);
        status("R4 code3", 32'h0000_3100);
        swrst();
        acc(1'b1, 8'h04, 32'h00E0_0000);
        status("R4 code4", 32'h0000_4100);
        chk("R4 prot kept", {26'b0, prot_bits}, 32'h3F);
        swrst();
        strobe(0, 0, 1, 0, 0);
        // R5
        acc(1'b0, 8'h24, 32'h0);
        chk("R5 key read zero", cap_rd, 32'h0);
        status("R5 code5 key", 32'h0000_5100);
        swrst();
        acc(1'b0, 8'h6C, 32'h0);
        status("R5 code5 vector", 32'h0000_5100);
        swrst();
        acc(1'b0, 8'h10, 32'h0);
        status("R5 code5 mask-set", 32'h0000_5100);
        swrst();
        // R2 idle read returns engine word
        acc(1'b0, 8'h58, 32'h0);
        chk("R2 idle read", cap_rd, 32'hA0A0_0002);
        // R9
        strobe(0, 0, 0, 1, 0);
        status("R9 data-ready set", 32'h0000_0001);
        chk("R8 irq on data-ready", {31'b0, irq}, 32'h1);
        acc(1'b0, 8'h5C, 32'h0);
        status("R9 cleared by read", 32'h0);
        strobe(0, 0, 0, 1, 0);
        acc(1'b1, 8'h00, 32'h0000_0001);
        status("R9 cleared by start", 32'h0);
        strobe(0, 0, 0, 0, 1);
        acc(1'b1, 8'h00, 32'h0000_0001);
        status("R9 tag survives start", 32'h0001_0000);
        chk("R8 irq on tag", {31'b0, irq}, 32'h1);
        swrst();
        status("R9 tag cleared by swrst", 32'h0);
        // R10
        strobe(1, 0, 1, 0, 0);
        acc(1'b1, 8'h04, 32'h0000_0000);
        chk("R10 end beats proc", {31'b0, viol_flag}, 32'h0);
        acc(1'b0, 8'h04, 32'h0);
        chk("R7 wrong key low bits", cap_rd, 32'h3F00_0000);
        strobe(1, 1, 0, 0, 0);
        acc(1'b0, 8'h50, 32'h0);
        status("R10 subkey beats proc", 32'h0000_3100);
        swrst();
        strobe(0, 0, 1, 0, 0);
        strobe(1, 0, 0, 0, 0);
        acc(1'b1, 8'h48, 32'h1234_5678);
        chk("R1 start mode 0 forwards", {31'b0, cap_en}, 32'h1);
        chk("R1 start mode 0 legal", {31'b0, viol_flag}, 32'h0);
        finish_run();
    end
endmodule